// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block raises an alarm when the running calendar reaches a time that software has programmed. Six byte-wide target registers hold BCD values for seconds, minutes, hours, day of week, day of month and month. Bit 7 of each target decides whether that field is compared at all. A field whose enable bit is clear is ignored. The alarm fires only when every enabled field agrees with the calendar.

The calendar counters are outside this block. They arrive as six 7-bit BCD buses, together with a one-cycle `tick` strobe that marks each seconds update. The compare is made only on a tick. A match sets a sticky alarm flag that software clears by writing zero to it. The interrupt output is that flag gated by an interrupt-enable bit. There is no year comparison. Software uses one byte-wide port with a shared address for reads and writes. Reads are combinational.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: After reset, every alarm target, the alarm flag and the interrupt enable read as zero, and `irq` is low.
- R2: Address 8+k holds the alarm target for field k, in the order seconds (8), minutes (9), hours (10), day of week (11), day of month (12), month (13). A write stores the whole byte and a read returns it. The month target uses the values 1 to 12 in BCD.
- R3: Address 14 is the control byte. Bit 3 is the interrupt enable, which is written directly and read back. Bit 0 is the alarm flag. The other bits read as zero. Any address other than 8 to 14 reads as zero, and a write to it changes no state.
- R4: On a cycle with `tick` high, if at least one target has bit 7 set and every target with bit 7 set has bits 6:0 equal to its calendar bus, the alarm flag reads as 1 from the next cycle.
- R5: A target with bit 7 clear (for example a target written as 0x00) does not take part in the compare, whatever its calendar bus holds.
- R6: When no target has bit 7 set, a tick never sets the flag.
- R7: With `tick` low, the flag is not set, even when every enabled field matches.
- R8: Once set, the flag stays set until a write to address 14 has bit 0 equal to 0. A write with bit 0 equal to 1 neither sets nor clears the flag.
- R9: `irq` equals the alarm flag ANDed with the interrupt enable. The flag is set whether or not the interrupt enable is 1.
- R10: When a matching tick and a flag-clearing write fall in the same cycle, the flag ends up set.
- R11: When a target is written in the same cycle as a tick, that tick is compared against the value the target held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 4 | Register index, used for both reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| tick | input | 1 | One-cycle strobe that marks a seconds update |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD |
| cur_wday | input | 7 | Current day of week, BCD |
| cur_mday | input | 7 | Current day of month, BCD |
| cur_mon | input | 7 | Current month, BCD 1 to 12 |
| irq | output | 1 | Alarm interrupt (flag AND enable) |

## Verification
The tick that sets the flag can land in the same cycle as a software write. That write may clear the flag, or it may rewrite a target that is being compared on that tick. The bench drives both collisions on purpose: a flag-clearing control write together with a matching tick, and a target rewrite during a tick in both directions (old match with new mismatch, and old mismatch with new match). Its reference model judges each case by setting before clearing and by comparing against pre-write targets. A long random phase uses a small pool of values, so that these collisions also occur unplanned, and it compares `irq` and `rdata` on every cycle.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int BCD_W      = 7;
  localparam int REG_W      = 8;
  localparam int EN_BIT     = REG_W - 1;
  localparam int FLAG_BIT   = 0;
  localparam int AIE_BIT    = 3;

  // a field passes when it is switched off or its target equals the calendar
  function automatic logic field_ok(input logic [REG_W-1:0] cfg,
                                    input logic [BCD_W-1:0] now);
    return !cfg[EN_BIT] || (cfg[BCD_W-1:0] == now);
  endfunction

  function automatic logic field_on(input logic [REG_W-1:0] cfg);
    return cfg[EN_BIT];
  endfunction
endpackage

// File: rtl/bcd_alarm_regs.sv
module bcd_alarm_regs
  import bcd_alarm_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int ALARM_BASE = 8,
  parameter int CTRL_IDX   = 14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [REG_W-1:0]            wdata,
  input  logic [REG_W-1:0]            ctrl_rd,
  output logic [NUM_FIELDS*REG_W-1:0] alarm_cfg,
  output logic [REG_W-1:0]            rdata,
  output logic                        ctrl_wr
);
  logic [NUM_FIELDS-1:0] sel;
  logic                  ctrl_sel;
  logic                  mapped;

  genvar k;
  generate
    for (k = 0; k < NUM_FIELDS; k++) begin : g_tgt
      assign sel[k] = (addr == ADDR_W'(ALARM_BASE + k));
      always_ff @(posedge clk) begin
        if (!rst_n)
          alarm_cfg[k*REG_W +: REG_W] <= '0;
        else if (wr_en && sel[k])
          alarm_cfg[k*REG_W +: REG_W] <= wdata;
      end
    end
  endgenerate

  assign ctrl_sel = (addr == ADDR_W'(CTRL_IDX));
  assign ctrl_wr  = wr_en && ctrl_sel;
  assign mapped   = ctrl_sel || (|sel);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (sel[i]) rdata = alarm_cfg[i*REG_W +: REG_W];
    if (ctrl_sel) rdata = ctrl_rd;
  end

  // R3: a write to an unmapped index leaves every target untouched
  p_unmapped_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> $stable(alarm_cfg));
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
  import bcd_alarm_pkg::*;
(
  input  logic [NUM_FIELDS*REG_W-1:0] alarm_cfg,
  input  logic [NUM_FIELDS*BCD_W-1:0] now,
  output logic                        hit,
  output logic [NUM_FIELDS-1:0]       en_mask
);
  logic [NUM_FIELDS-1:0] ok;

  genvar k;
  generate
    for (k = 0; k < NUM_FIELDS; k++) begin : g_cmp
      assign ok[k]      = field_ok(alarm_cfg[k*REG_W +: REG_W], now[k*BCD_W +: BCD_W]);
      assign en_mask[k] = field_on(alarm_cfg[k*REG_W +: REG_W]);
    end
  endgenerate

  assign hit = (&ok) && (|en_mask);
endmodule

// File: rtl/bcd_alarm_flag.sv
module bcd_alarm_flag
  import bcd_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hit,
  input  logic             ctrl_wr,
  input  logic [REG_W-1:0] wdata,
  output logic             flag,
  output logic             aie,
  output logic             irq
);
  logic set_ev, clr_ev;
  assign set_ev = tick && hit;
  assign clr_ev = ctrl_wr && !wdata[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      aie  <= 1'b0;
    end else begin
      if (set_ev)      flag <= 1'b1;
      else if (clr_ev) flag <= 1'b0;
      if (ctrl_wr)     aie  <= wdata[AIE_BIT];
    end
  end

  assign irq = flag && aie;

  p_match_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag);
  p_rise_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_ev));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_ev) |=> flag);
  p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev && clr_ev) |=> flag);
endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp
  import bcd_alarm_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int ALARM_BASE = 8,
  parameter int CTRL_IDX   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              tick,
  input  logic [BCD_W-1:0]  cur_sec,
  input  logic [BCD_W-1:0]  cur_min,
  input  logic [BCD_W-1:0]  cur_hour,
  input  logic [BCD_W-1:0]  cur_wday,
  input  logic [BCD_W-1:0]  cur_mday,
  input  logic [BCD_W-1:0]  cur_mon,
  output logic              irq
);
  logic [NUM_FIELDS*REG_W-1:0] alarm_cfg;
  logic [NUM_FIELDS*BCD_W-1:0] now;
  logic [NUM_FIELDS-1:0]       en_mask;
  logic [REG_W-1:0]            ctrl_rd;
  logic                        ctrl_wr, hit, flag, aie;

  assign now = {cur_mon, cur_mday, cur_wday, cur_hour, cur_min, cur_sec};

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[FLAG_BIT] = flag;
    ctrl_rd[AIE_BIT]  = aie;
  end

  bcd_alarm_regs #(.ADDR_W(ADDR_W), .ALARM_BASE(ALARM_BASE), .CTRL_IDX(CTRL_IDX)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl_rd(ctrl_rd), .alarm_cfg(alarm_cfg), .rdata(rdata), .ctrl_wr(ctrl_wr));

  bcd_alarm_match u_match (
    .alarm_cfg(alarm_cfg), .now(now), .hit(hit), .en_mask(en_mask));

  bcd_alarm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hit(hit), .ctrl_wr(ctrl_wr),
    .wdata(wdata), .flag(flag), .aie(aie), .irq(irq));

  // R6: with every field switched off a tick cannot raise the flag
  p_empty_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask == '0 && !flag) |=> !flag);
  // R7: the flag only rises after a tick
  p_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !flag) |=> !flag);
endmodule

// File: tb/bcd_alarm_cmp_test.sv
module bcd_alarm_cmp_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tick = 1'b0;
  logic [6:0] c_sec = '0, c_min = '0, c_hour = '0, c_wday = '0, c_mday = '0, c_mon = '0;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  int m_tgt[6];
  bit m_flag, m_aie;

  always #2.5 clk = ~clk;

  bcd_alarm_cmp uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .tick(tick), .cur_sec(c_sec), .cur_min(c_min), .cur_hour(c_hour), .cur_wday(c_wday),
    .cur_mday(c_mday), .cur_mon(c_mon), .irq(irq));

  function automatic int cur_of(int k);
    case (k)
      0: return int'(c_sec);
      1: return int'(c_min);
      2: return int'(c_hour);
      3: return int'(c_wday);
      4: return int'(c_mday);
      default: return int'(c_mon);
    endcase
  endfunction

  function automatic int model_read(int a);
    if (a >= 8 && a <= 13) return m_tgt[a-8];
    if (a == 14) return (m_aie ? 8 : 0) + (m_flag ? 1 : 0);
    return 0;
  endfunction

  task automatic model_clock();
    int n_on = 0;
    bit all_eq = 1;
    for (int k = 0; k < 6; k++) begin
      if (m_tgt[k] >= 128) begin
        n_on++;
        if ((m_tgt[k] - 128) != cur_of(k)) all_eq = 0;
      end
    end
    if (tick && n_on > 0 && all_eq) m_flag = 1;
    else if (wr_en && addr == 14 && wdata[0] == 1'b0) m_flag = 0;
    if (wr_en && addr == 14) m_aie = wdata[3];
    if (wr_en && addr >= 8 && addr <= 13) m_tgt[addr-8] = int'(wdata);
  endtask

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // drive at negedge, clock the model at posedge, compare at the next negedge
  task automatic step(bit w, int a, int d, bit t, string tag);
    wr_en = w; addr = 4'(a); wdata = 8'(d); tick = t;
    @(posedge clk);
    model_clock();
    @(negedge clk);
    check({tag, " irq"}, int'(irq), (m_flag && m_aie) ? 1 : 0);
    check({tag, " rdata"}, int'(rdata), model_read(a));
  endtask

  task automatic set_now(int s, int mi, int h, int wd, int md, int mo);
    c_sec = 7'(s); c_min = 7'(mi); c_hour = 7'(h);
    c_wday = 7'(wd); c_mday = 7'(md); c_mon = 7'(mo);
  endtask

  task automatic peek(int a, int exp, string tag);
    step(0, a, 0, 0, tag);
    check({tag, " direct"}, int'(rdata), exp);
  endtask

  initial begin
    for (int k = 0; k < 6; k++) m_tgt[k] = 0;
    m_flag = 0; m_aie = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 8; a <= 14; a++) peek(a, 0, "R1");
    check("R1 irq", int'(irq), 0);
    // R2 readback of each target, including month 12
    for (int k = 0; k < 6; k++) step(1, 8 + k, 8'h80 | (k + 1), 0, "R2");
    for (int k = 0; k < 6; k++) peek(8 + k, 8'h80 | (k + 1), "R2");
    step(1, 13, 8'h92, 0, "R2"); peek(13, 8'h92, "R2");
    // R3 control readback and unmapped addresses
    step(1, 14, 8'hFE, 0, "R3"); peek(14, 8'h08, "R3");
    step(1, 3, 8'hFF, 0, "R3"); peek(3, 0, "R3");
    step(1, 15, 8'hFF, 0, "R3"); peek(15, 0, "R3");
    for (int k = 0; k < 6; k++) step(1, 8 + k, 0, 0, "R3");
    step(1, 14, 0, 0, "R3");
    // R6 nothing enabled, all calendar zero
    set_now(0, 0, 0, 0, 0, 0);
    step(0, 14, 0, 1, "R6"); peek(14, 0, "R6");
    // R4/R5 only seconds enabled; R9 flag without enable
    step(1, 8, 8'hB0, 0, "R5");
    set_now(8'h30, 8'h17, 8'h05, 3, 8'h21, 8'h07);
    step(0, 14, 0, 1, "R5"); peek(14, 8'h01, "R9");
    check("R9 irq gated", int'(irq), 0);
    // R8 write 1 to flag keeps it and raises irq; write 0 clears
    step(1, 14, 8'h09, 0, "R8"); peek(14, 8'h09, "R8");
    check("R9 irq on", int'(irq), 1);
    step(1, 14, 8'h08, 0, "R8"); peek(14, 8'h08, "R8");
    step(1, 14, 8'h09, 0, "R8"); peek(14, 8'h08, "R8");
    // R4 all six enabled, one mismatch then all matching
    step(1, 9, 8'h97, 0, "R4"); step(1, 10, 8'h85, 0, "R4");
    step(1, 11, 8'h83, 0, "R4"); step(1, 12, 8'hA1, 0, "R4");
    step(1, 13, 8'h87, 0, "R4");
    set_now(8'h30, 8'h17, 8'h05, 3, 8'h21, 8'h08);
    step(0, 14, 0, 1, "R4"); peek(14, 8'h08, "R4");
    set_now(8'h30, 8'h17, 8'h05, 3, 8'h21, 8'h07);
    // R7 match without tick
    step(0, 14, 0, 0, "R7"); peek(14, 8'h08, "R7");
    step(0, 14, 0, 1, "R4"); peek(14, 8'h09, "R4");
    check("R4 irq", int'(irq), 1);
    // R10 clear and matching tick together
    step(1, 14, 8'h08, 1, "R10"); peek(14, 8'h09, "R10");
    step(1, 14, 8'h08, 0, "R10"); peek(14, 8'h08, "R10");
    // R11 rewrite during tick: old matches, new does not
    step(1, 8, 8'hA0, 1, "R11"); peek(14, 8'h09, "R11");
    step(1, 14, 8'h08, 0, "R11");
    // old mismatches (0x20 vs 0x30), new would match
    step(1, 8, 8'hB0, 1, "R11"); peek(14, 8'h08, "R11");
    // random phase over a small value pool
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 9);
      int a = $urandom_range(7, 15);
      int d = ($urandom_range(0, 1) ? 8'h80 : 0) | $urandom_range(0, 2);
      if (a == 14) d = $urandom_range(0, 255);
      set_now($urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 2),
              $urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 2));
      step(r < 3, a, d, r > 4, "R4 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule